// File: doc/BRIEF.md
# Recursive Karatsuba Integer Multiplier

This block multiplies two unsigned operands with no clock and no state. The product appears on the output once the inputs have propagated through the logic. Each operand is cut into an upper and a lower half. The product is then assembled from three half-width products:

- upper times upper,
- lower times lower,
- the product of the two half-sums.

The cross term comes from subtracting the first two products from the third. It is never multiplied directly. The same step is applied again inside each half-width product, so a 16-bit multiply descends through 8-bit and 4-bit stages down to a 2-bit multiply that is computed directly.

The half-sums carry one extra bit. That carry is not pushed into a wider sub-multiplier. Instead, each level multiplies only the lower bits of the sums and adds the carry contributions as gated shifted terms. This keeps every sub-multiplier at an exact power-of-two width. The operand width is a parameter and must be a power of two of at least 4.

Top module: `kara_mul`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `op_a` times `op_b` exactly, over the full 2·W-bit output (W = 16 by default).
- R2: When either operand is zero, `prod` is zero.
- R3: When both operands are all ones, `prod` equals 2^(2W) − 2^(W+1) + 1 (0xFFFE0001 for W = 16).
- R4: The upper sub-product equals upper half of `op_a` times upper half of `op_b`. The lower sub-product equals lower half times lower half. Halves are bits [W-1:W/2] and [W/2-1:0].
- R5: The middle term, formed as the product of half-sums minus both sub-products, equals upper(a)·lower(b) + lower(a)·upper(b).
- R6: The middle term never wraps. Its top bit, at position W+1 of its W+2-bit width, is always zero.
- R7: The result stays exact when the half-sums of either operand carry out of W/2 bits.
- R8: The output follows an input change within the same time step, with no clock edge involved.
- R9: At W = 4 and at W = 8 the product is exact for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Multiplicand, unsigned |
| op_b | input | W | Multiplier, unsigned |
| prod | output | 2*W | Unsigned product |

## Verification
The bound checker re-evaluates the following every time the inputs settle:
- the full product against a direct multiply;
- the zero and all-ones results;
- both top-level sub-products;
- the middle term against the four-product cross sum, and its no-wrap bit.

These checks reach only the top level, so the bench covers the rest. It sweeps every operand pair at widths 4 and 8, which reaches every recursion level and carry pattern through the output port. It also drives chosen 16-bit operands: half-sum carries, isolated halves, extremes, and a change between clock edges. A random sweep at 16 bits completes the stimulus.

// File: rtl/kara_pkg.sv
package kara_pkg;
  // width of one half of an operand of width n
  function automatic int unsigned half_w(input int unsigned n);
    return n / 2;
  endfunction

  // width needed for the middle term of an operand of width n
  function automatic int unsigned mid_w(input int unsigned n);
    return n + 2;
  endfunction
endpackage

// File: rtl/kara_base.sv
module kara_base #(
  parameter int N = 2
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int P = 2 * N;

  function automatic logic [P-1:0] direct_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    return P'(x) * P'(y);
  endfunction

  assign p = direct_mul(a, b);
endmodule

// File: rtl/kara_join.sv
module kara_join #(
  parameter int M = 4
) (
  input  logic [2*M-1:0] t2,
  input  logic [2*M-1:0] t0,
  input  logic [2*M-1:0] pl,
  input  logic           cx,
  input  logic           cy,
  input  logic [M-1:0]   sxl,
  input  logic [M-1:0]   syl,
  output logic [2*M+1:0] t1,
  output logic [4*M-1:0] p
);
  localparam int Q  = 2 * M + 2;
  localparam int P  = 4 * M;
  localparam int M2 = 2 * M;

  // (cx*2^M + sxl)(cy*2^M + syl) built from the low-bit product and gated carry terms
  function automatic logic [Q-1:0] fold_sum_product(
    input logic [M2-1:0] low_prod, input logic c_x, input logic c_y,
    input logic [M-1:0] lx, input logic [M-1:0] ly);
    logic [Q-1:0] acc;
    acc = Q'(low_prod);
    acc = acc + (Q'({M{c_x}} & ly) << M);
    acc = acc + (Q'({M{c_y}} & lx) << M);
    acc = acc + (Q'(c_x & c_y) << M2);
    return acc;
  endfunction

  function automatic logic [P-1:0] recombine(
    input logic [M2-1:0] hi, input logic [Q-1:0] mid, input logic [M2-1:0] lo);
    return (P'(hi) << M2) + (P'(mid) << M) + P'(lo);
  endfunction

  logic [Q-1:0] t3;

  assign t3 = fold_sum_product(pl, cx, cy, sxl, syl);
  assign t1 = t3 - Q'(t2) - Q'(t0);
  assign p  = recombine(t2, t1, t0);
endmodule

// File: rtl/kara_node.sv
module kara_node #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  import kara_pkg::*;

  generate
    if (N <= 2) begin : g_leaf
      kara_base #(.N(N)) u_base (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int M = half_w(N);
      logic [M-1:0]   ah, al, bh, bl;
      logic [M:0]     sa, sb;
      logic [2*M-1:0] t2, t0, pl;
      logic [2*M+1:0] t1;

      assign ah = a[N-1:M];
      assign al = a[M-1:0];
      assign bh = b[N-1:M];
      assign bl = b[M-1:0];
      assign sa = {1'b0, ah} + {1'b0, al};
      assign sb = {1'b0, bh} + {1'b0, bl};

      kara_node #(.N(M)) u_hi  (.a(ah), .b(bh), .p(t2));
      kara_node #(.N(M)) u_lo  (.a(al), .b(bl), .p(t0));
      kara_node #(.N(M)) u_mid (.a(sa[M-1:0]), .b(sb[M-1:0]), .p(pl));

      kara_join #(.M(M)) u_join (
        .t2(t2), .t0(t0), .pl(pl), .cx(sa[M]), .cy(sb[M]),
        .sxl(sa[M-1:0]), .syl(sb[M-1:0]), .t1(t1), .p(p)
      );

      // t1 is consumed inside u_join; the extra reference keeps the name for debug views
      logic t1_top_unused;
      assign t1_top_unused = t1[2*M+1];
    end
  endgenerate
endmodule

// File: rtl/kara_mul.sv
module kara_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  import kara_pkg::*;

  localparam int M = half_w(W);
  localparam int Q = mid_w(W);

  // named internal events observed by the bound checker
  logic [M-1:0]   x_hi, x_lo, y_hi, y_lo;
  logic [M:0]     sum_x, sum_y;
  logic [2*M-1:0] t2_w, t0_w, pl_w;
  logic [Q-1:0]   t1_w;

  assign x_hi  = op_a[W-1:M];
  assign x_lo  = op_a[M-1:0];
  assign y_hi  = op_b[W-1:M];
  assign y_lo  = op_b[M-1:0];
  assign sum_x = {1'b0, x_hi} + {1'b0, x_lo};
  assign sum_y = {1'b0, y_hi} + {1'b0, y_lo};

  kara_node #(.N(M)) u_hi  (.a(x_hi), .b(y_hi), .p(t2_w));
  kara_node #(.N(M)) u_lo  (.a(x_lo), .b(y_lo), .p(t0_w));
  kara_node #(.N(M)) u_mid (.a(sum_x[M-1:0]), .b(sum_y[M-1:0]), .p(pl_w));

  kara_join #(.M(M)) u_join (
    .t2(t2_w), .t0(t0_w), .pl(pl_w), .cx(sum_x[M]), .cy(sum_y[M]),
    .sxl(sum_x[M-1:0]), .syl(sum_y[M-1:0]), .t1(t1_w), .p(prod)
  );
endmodule

// File: rtl/kara_mul_chk.sv
module kara_mul_chk #(
  parameter int W = 16
) (
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic [2*W-1:0]   prod,
  input logic [W/2-1:0]   x_hi,
  input logic [W/2-1:0]   x_lo,
  input logic [W/2-1:0]   y_hi,
  input logic [W/2-1:0]   y_lo,
  input logic [W-1:0]     t2_w,
  input logic [W-1:0]     t0_w,
  input logic [W+1:0]     t1_w
);
  localparam int P = 2 * W;
  localparam int Q = W + 2;

  logic [P-1:0] ref_prod;
  logic [P-1:0] ones_sq;
  logic [Q-1:0] cross_sum;

  assign ref_prod  = P'(op_a) * P'(op_b);
  assign ones_sq   = {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1};
  assign cross_sum = Q'(x_hi) * Q'(y_lo) + Q'(x_lo) * Q'(y_hi);

  always_comb begin
    assert_exact_product_R1: assert (prod == ref_prod);
    if (op_a == '0 || op_b == '0)
      assert_zero_operand_R2: assert (prod == '0);
    if (&op_a && &op_b)
      assert_all_ones_R3: assert (prod == ones_sq);
    assert_upper_subproduct_R4: assert (t2_w == W'(x_hi) * W'(y_hi));
    assert_lower_subproduct_R4: assert (t0_w == W'(x_lo) * W'(y_lo));
    assert_middle_term_R5: assert (t1_w == cross_sum);
    assert_no_overflow_R6: assert (t1_w[Q-1] == 1'b0);
  end
endmodule

bind kara_mul kara_mul_chk #(.W(W)) u_chk (
  .op_a(op_a), .op_b(op_b), .prod(prod),
  .x_hi(x_hi), .x_lo(x_lo), .y_hi(y_hi), .y_lo(y_lo),
  .t2_w(t2_w), .t0_w(t0_w), .t1_w(t1_w)
);

// File: tb/kara_mul_bench.sv
`timescale 1ns/1ps
module kara_mul_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;

  kara_mul #(.W(16)) u_kara_mul    (.op_a(a16), .op_b(b16), .prod(p16));
  kara_mul #(.W(8))  u_kara_mul_w8 (.op_a(a8),  .op_b(b8),  .prod(p8));
  kara_mul #(.W(4))  u_kara_mul_w4 (.op_a(a4),  .op_b(b4),  .prod(p4));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected product by shift-and-add, independent of any multiply operator
  function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
    logic [63:0] acc = '0;
    for (int i = 0; i < 32; i++)
      if (y[i]) acc = acc + ({32'd0, x} << i);
    return acc;
  endfunction

  task automatic drive16(input string req, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    a16 = x; b16 = y;
    #0.5;
    chk(req, {32'd0, p16}, ref_mul({16'd0, x}, {16'd0, y}));
  endtask

  initial begin
    #(4.0 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    a16 = '0; b16 = '0; a8 = '0; b8 = '0; a4 = '0; b4 = '0;
    @(negedge clk);
    chk("R2 reset-state zero", {32'd0, p16}, 64'd0);

    // R2: zero operand on either side
    drive16("R2", 16'h0000, 16'hBEEF);
    drive16("R2", 16'hFFFF, 16'h0000);
    // R3: all ones squared
    @(negedge clk);
    a16 = 16'hFFFF; b16 = 16'hFFFF;
    #0.5;
    chk("R3", {32'd0, p16}, 64'h0000_0000_FFFE_0001);
    // R4: only upper halves, only lower halves
    drive16("R4 upper", 16'h1200, 16'h3400);
    drive16("R4 lower", 16'h00AB, 16'h00CD);
    // R5: only cross terms contribute
    drive16("R5", 16'h5600, 16'h0078);
    drive16("R5", 16'h0099, 16'hEE00);
    // R6: largest middle terms
    drive16("R6", 16'hFF01, 16'h01FF);
    drive16("R6", 16'hFFFF, 16'hFF00);
    // R7: half-sums carry out
    drive16("R7 both carry", 16'h8080, 16'h8080);
    drive16("R7 a carry", 16'hF0F0, 16'h0101);
    drive16("R7 b carry", 16'h0001, 16'hC0C0);
    drive16("R7 mixed", 16'hFFFE, 16'h9F71);

    // R8: change inputs between edges and look before the next edge
    @(posedge clk);
    #0.5;
    a16 = 16'h1234; b16 = 16'h5678;
    #0.5;
    chk("R8 mid-cycle", {32'd0, p16}, ref_mul(32'h1234, 32'h5678));
    a16 = 16'hA5A5;
    #0.5;
    chk("R8 follow", {32'd0, p16}, ref_mul(32'hA5A5, 32'h5678));

    // R1: random operand pairs at full width
    for (int k = 0; k < 3000; k++) begin
      drive16("R1 random", 16'($urandom), 16'($urandom));
    end

    // R9: exhaustive at W=4
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        a4 = 4'(i); b4 = 4'(j);
        #0.5;
        chk("R9 w4", {56'd0, p4}, ref_mul(32'(i), 32'(j)));
      end
    end

    // R9: exhaustive at W=8
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a8 = 8'(i); b8 = 8'(j);
        #0.5;
        chk("R9 w8", {48'd0, p8}, ref_mul(32'(i), 32'(j)));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule